// File: doc/BRIEF.md
# USB OUT Endpoint Receive Buffer Handoff

This block holds the receive buffer of one OUT endpoint. It passes the buffer back and forth between a USB packet engine and firmware. The engine streams received bytes into the buffer and closes each packet with a good or bad status. Once a good packet is accepted, ownership moves to firmware. From then on the engine sees a NAK indication and its traffic is ignored. Firmware reads the packet length from a read-only count, then pulls the bytes out through a single data port that steps an internal pointer on every access.

When firmware has read the data, it sets a release bit. The bit reads back as set for one cycle. Hardware then performs the release and clears the bit: the count returns to zero, ownership goes back to the engine, and the next OUT transaction can land in the buffer. A packet that ends bad, or that tries to store more bytes than the buffer holds, is dropped. The write position rewinds and the engine keeps ownership.

Top module: `usb_out_rxbuf`

## Requirements
- R1: After reset, fw_count is 0, fw_pkt_ready is 0, eng_nak is 0, eng_ovf is 0, fw_rel_bit is 0 and fw_rdata is 0.
- R2: A good end after N bytes (0 < N ≤ DEPTH) sets fw_pkt_ready and eng_nak and loads fw_count with N. These changes are visible in the cycle after the end strobe.
- R3: A fw_rd pulse while firmware owns the buffer places the next stored byte on fw_rdata in the following cycle, in arrival order. A fw_rd pulse once all fw_count bytes are read, or while the engine owns the buffer, leaves fw_rdata and the read position unchanged.
- R4: fw_rel_set while firmware owns the buffer makes fw_rel_bit read 1 in the next cycle. One cycle later fw_rel_bit is 0, fw_pkt_ready is 0, eng_nak is 0 and fw_count is 0.
- R5: fw_rel_set while the engine owns the buffer has no effect: fw_rel_bit stays 0, and a packet in progress completes with all its bytes.
- R6: While firmware owns the buffer, engine bytes and end strobes are ignored: fw_count and the stored data stay unchanged and eng_nak stays 1.
- R7: A bad end discards the packet: ownership stays with the engine, fw_count stays 0, and the next packet is stored from the first location.
- R8: A byte offered when DEPTH bytes are already stored sets eng_ovf. eng_ovf holds until the end strobe and is 0 after it. That packet is discarded even with good status.
- R9: A packet of exactly DEPTH bytes is accepted with eng_ovf staying 0 and fw_count equal to DEPTH.
- R10: A good end with no bytes hands the buffer to firmware with fw_count 0; reads then leave fw_rdata unchanged.
- R11: A byte strobed in the same cycle as the end strobe is stored as the packet's last byte and is counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| eng_wr | input | 1 | Engine byte strobe |
| eng_data | input | DW | Engine byte value |
| eng_end | input | 1 | End of packet strobe |
| eng_good | input | 1 | Packet status with eng_end, 1 = good |
| eng_nak | output | 1 | Buffer held by firmware; engine must NAK |
| eng_ovf | output | 1 | Current packet overran the buffer |
| fw_rd | input | 1 | Firmware data port read strobe |
| fw_rdata | output | DW | Byte returned by the last valid read |
| fw_count | output | CW | Accepted packet length, CW = clog2(DEPTH+1) |
| fw_pkt_ready | output | 1 | Firmware owns the buffer |
| fw_rel_set | input | 1 | Firmware write of 1 to the release bit |
| fw_rel_bit | output | 1 | Release bit readback, self-clearing |

## Verification
The bench builds the block with DEPTH = 16 and DW = 8, so the full-buffer and one-byte-over cases take only a handful of cycles. At that size the bench also reaches the exact-fit packet, an overflowing packet that still ends good, and a zero-length packet. With the default DEPTH of 64 the same checks apply unchanged. The count width follows DEPTH, so the bench's 5-bit count exercises the derived width rather than a fixed one.

// File: rtl/usb_rxbuf_pkg.sv
// Shared types for the OUT endpoint receive buffer.
// Assumes: a single buffer with exactly two possible owners.
package usb_rxbuf_pkg;
    typedef enum logic {
        OWN_ENG = 1'b0,
        OWN_FW  = 1'b1
    } buf_owner_e;
endpackage

// File: rtl/rxbuf_mem.sv
// Byte storage for the receive buffer: one synchronous write port and one
// asynchronous read port.
// Assumes: waddr is in range whenever we is high; contents are not reset.
module rxbuf_mem #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    // Store an engine byte at the write position.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Present the byte at the read position.
    assign rdata = mem[raddr];
endmodule

// File: rtl/rxbuf_wr_ctrl.sv
// Engine-side write control: tracks the write position, flags overflow and
// decides whether an end strobe accepts the packet.
// Assumes: engine traffic is ignored while firmware owns the buffer; a byte
// strobed together with the end strobe belongs to the packet.
module rxbuf_wr_ctrl #(
    parameter int DEPTH = 64,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          eng_wr,
    input  logic          eng_end,
    input  logic          eng_good,
    input  logic          own_fw,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic          accept,
    output logic [CW-1:0] acc_len,
    output logic          ovf
);
    logic [CW-1:0] wr_ptr;
    logic          ovf_q;
    logic          active;
    logic          full;
    logic          ovf_wr;

    // Decode this cycle's write, overflow and acceptance.
    always_comb begin
        active  = !own_fw;
        full    = (wr_ptr == CW'(DEPTH));
        we      = active && eng_wr && !full;
        ovf_wr  = active && eng_wr && full;
        accept  = active && eng_end && eng_good && !(ovf_q || ovf_wr);
        acc_len = wr_ptr + CW'(we);
        waddr   = AW'(wr_ptr);
    end

    // Advance or rewind the write position and track overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            ovf_q  <= 1'b0;
        end else if (active && eng_end) begin
            wr_ptr <= '0;
            ovf_q  <= 1'b0;
        end else begin
            if (we)     wr_ptr <= wr_ptr + 1'b1;
            if (ovf_wr) ovf_q  <= 1'b1;
        end
    end

    assign ovf = ovf_q;

    // While firmware owns the buffer the writer is idle at the start.
    assert_wr_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        own_fw |-> (wr_ptr == '0 && !ovf_q));

    // Overflow stays flagged until the packet ends.
    assert_ovf_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !eng_end) |=> ovf_q);

    // The write position never passes the buffer size.
    assert_wr_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ptr <= CW'(DEPTH));
endmodule

// File: rtl/rxbuf_own_ctrl.sv
// Ownership control: holds the owner flag, the accepted byte count and the
// self-clearing release bit.
// Assumes: a release requested while firmware owns the buffer executes in the
// cycle after the request.
module rxbuf_own_ctrl
    import usb_rxbuf_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic [CW-1:0] acc_len,
    input  logic          fw_rel_set,
    output logic          own_fw,
    output logic [CW-1:0] count,
    output logic          rel_q
);
    buf_owner_e owner_q;
    logic [CW-1:0] count_q;

    // Hand the buffer over on acceptance and back on release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q <= OWN_ENG;
            count_q <= '0;
            rel_q   <= 1'b0;
        end else if (rel_q) begin
            owner_q <= OWN_ENG;
            count_q <= '0;
            rel_q   <= 1'b0;
        end else if (owner_q == OWN_FW) begin
            if (fw_rel_set) rel_q <= 1'b1;
        end else if (accept) begin
            owner_q <= OWN_FW;
            count_q <= acc_len;
        end
    end

    assign own_fw = (owner_q == OWN_FW);
    assign count  = count_q;

    // An accepted packet moves the buffer to firmware with its length.
    assert_accept_hands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (own_fw && count_q == $past(acc_len)));

    // The count never exceeds the buffer size.
    assert_count_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CW'(DEPTH));

    // The release bit is set for one cycle only.
    assert_rel_selfclear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rel_q |=> !rel_q);

    // A release returns the buffer and clears the count.
    assert_rel_frees_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rel_q |=> (!own_fw && count_q == '0));

    // The release bit is only ever set while firmware owns the buffer.
    assert_rel_owned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rel_q |-> own_fw);

    // Firmware ownership and count hold until a release executes.
    assert_fw_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (own_fw && !rel_q) |=> (own_fw && $stable(count_q)));
endmodule

// File: rtl/rxbuf_rd_port.sv
// Firmware data port: each valid read strobe latches the byte at the read
// position and advances it.
// Assumes: reads are honoured only while firmware owns the buffer, no release
// is executing, and unread bytes remain.
module rxbuf_rd_port #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          own_fw,
    input  logic          rel_q,
    input  logic [CW-1:0] count,
    input  logic          fw_rd,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [CW-1:0] rd_ptr;
    logic          can_rd;

    // Decide whether the read strobe is honoured this cycle.
    assign can_rd = own_fw && !rel_q && fw_rd && (rd_ptr < count);
    assign raddr  = AW'(rd_ptr);

    // Latch the byte and step the read position; rewind on release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            rdata  <= '0;
        end else if (rel_q) begin
            rd_ptr <= '0;
        end else if (can_rd) begin
            rdata  <= mem_rdata;
            rd_ptr <= rd_ptr + 1'b1;
        end
    end

    // The read position never passes the stored length.
    assert_rd_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ptr <= count);

    // Read data changes only as the result of an honoured read.
    assert_rdata_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !can_rd |=> $stable(rdata));
endmodule

// File: rtl/usb_out_rxbuf.sv
// OUT endpoint receive buffer shared by a USB packet engine and firmware.
// Connects storage, the engine writer, ownership control and the firmware
// read port.
// Assumes: one endpoint; serial decoding and CRC are done upstream and show
// up only as the status on the end strobe.
module usb_out_rxbuf #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          eng_wr,
    input  logic [DW-1:0] eng_data,
    input  logic          eng_end,
    input  logic          eng_good,
    output logic          eng_nak,
    output logic          eng_ovf,
    input  logic          fw_rd,
    output logic [DW-1:0] fw_rdata,
    output logic [CW-1:0] fw_count,
    output logic          fw_pkt_ready,
    input  logic          fw_rel_set,
    output logic          fw_rel_bit
);
    logic          we;
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;
    logic [DW-1:0] mem_rdata;
    logic          accept;
    logic [CW-1:0] acc_len;
    logic          own_fw;
    logic          rel_q;
    logic [CW-1:0] count;

    rxbuf_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
        .clk   (clk),
        .we    (we),
        .waddr (waddr),
        .wdata (eng_data),
        .raddr (raddr),
        .rdata (mem_rdata)
    );

    rxbuf_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .eng_wr   (eng_wr),
        .eng_end  (eng_end),
        .eng_good (eng_good),
        .own_fw   (own_fw),
        .we       (we),
        .waddr    (waddr),
        .accept   (accept),
        .acc_len  (acc_len),
        .ovf      (eng_ovf)
    );

    rxbuf_own_ctrl #(.DEPTH(DEPTH)) u_own (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .acc_len    (acc_len),
        .fw_rel_set (fw_rel_set),
        .own_fw     (own_fw),
        .count      (count),
        .rel_q      (rel_q)
    );

    rxbuf_rd_port #(.DEPTH(DEPTH), .DW(DW)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .own_fw    (own_fw),
        .rel_q     (rel_q),
        .count     (count),
        .fw_rd     (fw_rd),
        .mem_rdata (mem_rdata),
        .raddr     (raddr),
        .rdata     (fw_rdata)
    );

    // Drive the status outputs from ownership state.
    assign eng_nak      = own_fw;
    assign fw_pkt_ready = own_fw;
    assign fw_count     = count;
    assign fw_rel_bit   = rel_q;

    // The engine never sees NAK and overflow together.
    assert_nak_ovf_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(eng_nak && eng_ovf));
endmodule

// File: tb/sim_usb_out_rxbuf.sv
// Scoreboard bench: driver tasks queue the bytes firmware should read back,
// and a monitor pops and compares them as the data port delivers them.
module sim_usb_out_rxbuf;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int DW         = 8;
    localparam int CW         = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          eng_wr, eng_end, eng_good;
    logic [DW-1:0] eng_data;
    logic          eng_nak, eng_ovf;
    logic          fw_rd, fw_rel_set;
    logic [DW-1:0] fw_rdata;
    logic [CW-1:0] fw_count;
    logic          fw_pkt_ready, fw_rel_bit;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [DW-1:0] exp_q [$];
    logic          rd_exp = 1'b0;
    logic          mon_fire = 1'b0;

    usb_out_rxbuf #(.DEPTH(DEPTH), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .eng_wr(eng_wr), .eng_data(eng_data), .eng_end(eng_end), .eng_good(eng_good),
        .eng_nak(eng_nak), .eng_ovf(eng_ovf),
        .fw_rd(fw_rd), .fw_rdata(fw_rdata), .fw_count(fw_count),
        .fw_pkt_ready(fw_pkt_ready), .fw_rel_set(fw_rel_set), .fw_rel_bit(fw_rel_bit)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: a valid read issued before this edge is compared at the next negedge.
    always @(posedge clk) mon_fire <= rd_exp;

    always @(negedge clk) begin : monitor
        logic [DW-1:0] e;
        if (mon_fire) begin
            if (exp_q.size() == 0) begin
                check("R3 unexpected read data", int'(fw_rdata), -1);
            end else begin
                e = exp_q.pop_front();
                check("R3 read data order", int'(fw_rdata), int'(e));
            end
        end
    end

    task automatic expect_bytes(int n, int base);
        for (int i = 0; i < n; i++) exp_q.push_back(DW'(base + i));
    endtask

    task automatic put_bytes(int n, int base);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            eng_wr   = 1'b1;
            eng_data = DW'(base + i);
        end
        @(negedge clk);
        eng_wr = 1'b0;
    endtask

    task automatic end_pkt(bit good);
        @(negedge clk);
        eng_end  = 1'b1;
        eng_good = good;
        @(negedge clk);
        eng_end  = 1'b0;
    endtask

    task automatic fw_read(int n, bit valid);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            fw_rd  = 1'b1;
            rd_exp = valid;
            @(negedge clk);
            fw_rd  = 1'b0;
            rd_exp = 1'b0;
        end
    endtask

    task automatic release_buf();
        @(negedge clk);
        fw_rel_set = 1'b1;
        @(negedge clk);
        fw_rel_set = 1'b0;
        check("R4 release bit reads set", int'(fw_rel_bit), 1);
        @(negedge clk);
        check("R4 release bit self-clears", int'(fw_rel_bit), 0);
        check("R4 ownership back to engine", int'(fw_pkt_ready), 0);
        check("R4 count cleared", int'(fw_count), 0);
        check("R4 nak dropped", int'(eng_nak), 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            check("watchdog expired", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : driver
        logic [DW-1:0] held;
        rst_n = 1'b0; eng_wr = 1'b0; eng_end = 1'b0; eng_good = 1'b0;
        eng_data = '0; fw_rd = 1'b0; fw_rel_set = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1 count", int'(fw_count), 0);
        check("R1 ready", int'(fw_pkt_ready), 0);
        check("R1 nak", int'(eng_nak), 0);
        check("R1 ovf", int'(eng_ovf), 0);
        check("R1 rel bit", int'(fw_rel_bit), 0);
        check("R1 rdata", int'(fw_rdata), 0);

        // R2: good 5-byte packet
        put_bytes(5, 8'h10);
        end_pkt(1'b1);
        expect_bytes(5, 8'h10);
        check("R2 ready", int'(fw_pkt_ready), 1);
        check("R2 nak", int'(eng_nak), 1);
        check("R2 count", int'(fw_count), 5);

        // R6: engine traffic ignored while firmware owns
        put_bytes(3, 8'hA0);
        end_pkt(1'b1);
        check("R6 count held", int'(fw_count), 5);
        check("R6 nak held", int'(eng_nak), 1);
        fw_read(5, 1'b1);
        // R3: read past the end leaves data unchanged
        held = fw_rdata;
        fw_read(1, 1'b0);
        check("R3 over-read holds data", int'(fw_rdata), int'(held));
        release_buf();
        // R3: read while engine owns leaves data unchanged
        fw_read(1, 1'b0);
        check("R3 engine-owned read holds data", int'(fw_rdata), int'(held));

        // R5: release request while engine owns, mid-packet
        put_bytes(2, 8'h30);
        @(negedge clk); fw_rel_set = 1'b1;
        @(negedge clk); fw_rel_set = 1'b0;
        check("R5 rel bit stays clear", int'(fw_rel_bit), 0);
        put_bytes(2, 8'h32);
        end_pkt(1'b1);
        expect_bytes(4, 8'h30);
        check("R5 packet completes", int'(fw_count), 4);
        fw_read(4, 1'b1);
        release_buf();

        // R7: bad end discards, next packet starts at first location
        put_bytes(3, 8'h50);
        end_pkt(1'b0);
        check("R7 ready stays clear", int'(fw_pkt_ready), 0);
        check("R7 count stays zero", int'(fw_count), 0);
        put_bytes(2, 8'h60);
        end_pkt(1'b1);
        expect_bytes(2, 8'h60);
        check("R7 next packet count", int'(fw_count), 2);
        fw_read(2, 1'b1);
        release_buf();

        // R8: overflow by one byte
        put_bytes(DEPTH + 1, 8'h70);
        check("R8 ovf set", int'(eng_ovf), 1);
        end_pkt(1'b1);
        check("R8 ovf cleared", int'(eng_ovf), 0);
        check("R8 packet dropped", int'(fw_pkt_ready), 0);
        check("R8 count zero", int'(fw_count), 0);

        // R9: exact fit
        put_bytes(DEPTH, 8'h80);
        check("R9 no ovf", int'(eng_ovf), 0);
        end_pkt(1'b1);
        expect_bytes(DEPTH, 8'h80);
        check("R9 count full", int'(fw_count), DEPTH);
        fw_read(DEPTH, 1'b1);
        release_buf();

        // R10: zero-length packet
        held = fw_rdata;
        end_pkt(1'b1);
        check("R10 ready", int'(fw_pkt_ready), 1);
        check("R10 count", int'(fw_count), 0);
        fw_read(1, 1'b0);
        check("R10 read holds data", int'(fw_rdata), int'(held));
        release_buf();

        // R11: last byte strobed together with the end
        put_bytes(2, 8'hC0);
        @(negedge clk);
        eng_wr = 1'b1; eng_data = 8'hC2; eng_end = 1'b1; eng_good = 1'b1;
        @(negedge clk);
        eng_wr = 1'b0; eng_end = 1'b0;
        expect_bytes(3, 8'hC0);
        check("R11 count includes last byte", int'(fw_count), 3);
        fw_read(3, 1'b1);
        release_buf();

        @(negedge clk);
        check("R3 scoreboard drained", exp_q.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule